// File: doc/BRIEF.md
# Bit-Synchronous Flag-Framed Serial Transmitter

The block turns a stream of bytes into a single-line bit-synchronous serial signal. Frames of payload bytes are set off by a fixed flag octet (0x7E), and the same flag is repeated while the line has nothing to carry. Inside a frame, a zero is forced into the stream after every fifth consecutive one bit. A receiver can therefore never mistake payload for a flag, and the line keeps changing level often enough for clock recovery. One bit leaves per clock cycle. Bytes go out most significant bit first. The bit stream is line coded so that a zero appears as a level change and a one as a held level.

Bytes are offered on a valid/ready port with start-of-frame and end-of-frame marks. The block accepts a byte only at the last bit period of the unit it is currently sending. If no byte is waiting at that moment inside a frame, the block closes the frame with a flag instead of stalling the line. The line output is registered on the falling clock edge, so its changes fall midway between the rising edges at which a receiver samples.

Top module: `hdlc_frame_tx`

## Requirements
- R1: While reset is asserted `line_out` is 1 and `in_ready` is 0. After reset, if no byte is offered, the line carries back-to-back flag octets 0x7E and no frame.
- R2: Each bit period that carries a zero changes the line level. Each bit period that carries a one keeps the level of the previous period.
- R3: Flags and payload bytes are sent most significant bit first. A decoded payload byte equals the byte accepted.
- R4: Inside a frame, a zero is inserted after any five consecutive payload ones. The run count carries across adjacent bytes of a frame and restarts after every zero sent, whether payload or inserted, and at every flag.
- R5: Flag octets are never stuffed, so six consecutive ones appear on the decoded line only within a flag.
- R6: A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only in the last bit period of the current unit, counting a trailing inserted zero. Successive accepts inside a frame are therefore 8 periods apart plus one period per zero inserted into the earlier byte.
- R7: When the line is idle, an offered byte is taken at the end of the flag being sent, within 8 cycles. That flag serves as the opening flag of the frame.
- R8: A byte accepted with `in_eof` = 1 is followed by a flag, which ends the frame.
- R9: If no byte is valid at a unit boundary inside a frame, a flag is sent and the frame ends after the bytes already sent.
- R10: Inside a frame, a byte offered with `in_sof` = 1 is not taken at the next boundary. A closing flag is sent first, and the byte is taken at the end of that flag as the first byte of a new frame, 16 periods after the previous accept when that byte had no inserted zero.
- R11: `line_out` changes only on the falling clock edge and is stable across every rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; rising edge advances the bit engine, falling edge updates the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered |
| in_data | input | BITS (8) | Offered byte |
| in_sof | input | 1 | Offered byte opens a new frame |
| in_eof | input | 1 | Offered byte is the last of its frame |
| in_ready | output | 1 | Block takes the offered byte on the next rising edge |
| line_out | output | 1 | Line-coded serial output |

## Verification
The tight coincidence is a zero inserted at the very end of a byte landing on the handshake boundary. The extra period must push `in_ready` back by one cycle, and the run count must restart before the next byte begins. The bench provokes this with the sequence 0x00, 0x1F, 0x00 in one frame. It judges the result in two ways: the spacing between accept edges must be 8 and then 9 cycles, and a bench-side line decoder must recover the three bytes intact. A second coincidence is a start-of-frame mark arriving exactly at a payload boundary. This is judged by a 16-cycle accept gap and by two separate frames on the decoded line.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic {UNIT_FLAG = 1'b0, UNIT_DATA = 1'b1} unit_e;

  // A stuffed zero is owed when this one bit completes the allowed run.
  function automatic logic stuff_due(input int ones_seen, input logic bit_now, input int run_len);
    return bit_now && (ones_seen == run_len - 1);
  endfunction

  // Line code: zero flips the level, one keeps it.
  function automatic logic line_next(input logic level, input logic bit_now);
    return bit_now ? level : ~level;
  endfunction

endpackage

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter
  import hdlc_tx_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            next_is_flag,
  input  logic [BITS-1:0] next_word,
  output logic            raw_bit,
  output logic            stuff_now,
  output logic            unit_end,
  output logic            unit_is_flag
);
  localparam int CW = $clog2(BITS + 1);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [BITS-1:0] FLAG_WORD = {1'b0, {(BITS-2){1'b1}}, 1'b0};

  logic [BITS-1:0] shreg;
  logic [CW-1:0]   cnt;
  logic [OW-1:0]   ones;
  logic [OW-1:0]   ones_next;
  logic            stuff_pend;
  unit_e           kind;
  logic            need_stuff;

  assign unit_is_flag = (kind == UNIT_FLAG);
  assign stuff_now    = stuff_pend;
  assign raw_bit      = stuff_pend ? 1'b0 : shreg[BITS-1];
  assign need_stuff   = (kind == UNIT_DATA) && !stuff_pend &&
                        stuff_due(int'(ones), shreg[BITS-1], STUFF_RUN);

  // The unit ends on its last data bit unless a zero is owed, else on that zero.
  assign unit_end = stuff_pend ? (cnt == CW'(BITS))
                               : ((cnt == CW'(BITS - 1)) && !need_stuff);

  always_comb begin
    if (kind == UNIT_FLAG || stuff_pend || !shreg[BITS-1]) ones_next = '0;
    else                                                    ones_next = ones + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= FLAG_WORD;
      kind       <= UNIT_FLAG;
      cnt        <= '0;
      ones       <= '0;
      stuff_pend <= 1'b0;
    end else if (unit_end) begin
      shreg      <= next_is_flag ? FLAG_WORD : next_word;
      kind       <= next_is_flag ? UNIT_FLAG : UNIT_DATA;
      cnt        <= '0;
      ones       <= next_is_flag ? '0 : ones_next;
      stuff_pend <= 1'b0;
    end else if (stuff_pend) begin
      stuff_pend <= 1'b0;
      ones       <= '0;
    end else begin
      shreg      <= {shreg[BITS-2:0], 1'b0};
      cnt        <= cnt + 1'b1;
      ones       <= ones_next;
      stuff_pend <= need_stuff;
    end
  end

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unit_end,
  input  logic            unit_is_flag,
  input  logic            in_valid,
  input  logic [BITS-1:0] in_data,
  input  logic            in_sof,
  input  logic            in_eof,
  output logic            in_ready,
  output logic            accept,
  output logic            next_is_flag,
  output logic [BITS-1:0] next_word
);
  logic close_pend;
  logic take_ok;

  // After a flag any byte may start a frame; inside a frame only a
  // continuation byte is taken, and not after an end-of-frame byte.
  assign take_ok      = unit_is_flag || (!close_pend && !in_sof);
  assign in_ready     = unit_end && take_ok;
  assign accept       = in_ready && in_valid;
  assign next_is_flag = !accept;
  assign next_word    = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        close_pend <= 1'b0;
    else if (unit_end) close_pend <= accept && in_eof;
  end

endmodule

// File: rtl/hdlc_tx_line_enc.sv
module hdlc_tx_line_enc
  import hdlc_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_bit,
  output logic enc_lvl,
  output logic line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enc_lvl <= 1'b1;
    else        enc_lvl <= line_next(enc_lvl, raw_bit);
  end

  // Retimed to the falling edge so the line moves between sampling edges.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= enc_lvl;
  end

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx #(
  parameter int BITS      = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [BITS-1:0] in_data,
  input  logic            in_sof,
  input  logic            in_eof,
  output logic            in_ready,
  output logic            line_out
);
  logic            unit_end;
  logic            unit_is_flag;
  logic            stuff_now;
  logic            raw_bit;
  logic            accept;
  logic            enc_lvl;
  logic            next_is_flag;
  logic [BITS-1:0] next_word;

  hdlc_tx_ctrl #(.BITS(BITS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .unit_end(unit_end), .unit_is_flag(unit_is_flag),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .accept(accept), .next_is_flag(next_is_flag),
    .next_word(next_word)
  );

  hdlc_tx_shifter #(.BITS(BITS), .STUFF_RUN(STUFF_RUN)) shift_i (
    .clk(clk), .rst_n(rst_n), .next_is_flag(next_is_flag), .next_word(next_word),
    .raw_bit(raw_bit), .stuff_now(stuff_now), .unit_end(unit_end),
    .unit_is_flag(unit_is_flag)
  );

  hdlc_tx_line_enc enc_i (
    .clk(clk), .rst_n(rst_n), .raw_bit(raw_bit), .enc_lvl(enc_lvl), .line_q(line_out)
  );

endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk #(
  parameter int BITS      = 8,
  parameter int STUFF_RUN = 5
) (
  input logic clk,
  input logic rst_n,
  input logic raw_bit,
  input logic unit_is_flag,
  input logic stuff_now,
  input logic accept,
  input logic enc_lvl,
  input logic line_out
);
  int   run;
  int   gap;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 0;
      gap  <= 0;
      seen <= 1'b0;
    end else begin
      run <= (unit_is_flag || !raw_bit) ? 0 : run + 1;
      if (accept) begin
        gap  <= 0;
        seen <= 1'b1;
      end else if (gap < 1000) begin
        gap <= gap + 1;
      end
    end
  end

  // R2
  zero_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_bit |=> enc_lvl != $past(enc_lvl));

  // R2
  one_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_bit |=> $stable(enc_lvl));

  // R4
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_is_flag && run == STUFF_RUN) |-> !raw_bit);

  // R5
  flag_unstuffed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_is_flag |-> !stuff_now);

  // R6
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seen) |-> gap >= BITS - 1);

  // R11
  edge_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_out == enc_lvl);

endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk #(.BITS(BITS), .STUFF_RUN(STUFF_RUN)) chk_i (
  .clk(clk), .rst_n(rst_n), .raw_bit(raw_bit), .unit_is_flag(unit_is_flag),
  .stuff_now(stuff_now), .accept(accept), .enc_lvl(enc_lvl), .line_out(line_out)
);

// File: tb/hdlc_frame_tx_tb_top.sv
`timescale 1ns/1ps
module hdlc_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       in_ready;
  logic       line_out;

  always #2 clk = ~clk;

  hdlc_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .line_out(line_out)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Row: {sof, eof, byte}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {2'b10, 8'h7E}, {2'b00, 8'hFF}, {2'b00, 8'h1F}, {2'b00, 8'hF8},
    {2'b01, 8'h3C}, {2'b11, 8'hA5}, {2'b10, 8'h00}, {2'b01, 8'h81}
  };

  always @(posedge clk) cyc++;

  // Independent line decoder (receiver model)
  logic prev_lvl = 1'b1;
  int   ones = 0;
  bit   sync = 0;
  bit   bitbuf [0:4095];
  int   nb = 0;
  int   rx_byte [0:255];
  bit   rx_last [0:255];
  int   rx_n = 0;
  int   flag_cnt = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      automatic bit b = (line_out == prev_lvl);
      prev_lvl = line_out;
      if (b) begin
        ones++;
        if (ones > 6) begin
          sync = 0;
          nb = 0;
        end else if (sync && nb < 4096) begin
          bitbuf[nb] = 1'b1;
          nb++;
        end
      end else begin
        if (ones == 6) begin
          flag_cnt++;
          if (sync && nb >= 7) begin
            automatic int pl = nb - 7;
            if (pl > 0 && pl % 8 == 0) begin
              for (int k = 0; k < pl / 8; k++) begin
                automatic int v = 0;
                for (int j = 0; j < 8; j++) v = (v << 1) | int'(bitbuf[k*8 + j]);
                rx_byte[rx_n] = v;
                rx_last[rx_n] = (k == pl / 8 - 1);
                rx_n++;
              end
            end
          end
          sync = 1;
          nb = 0;
        end else if (ones == 5 && sync) begin
          // inserted zero dropped
        end else if (sync && nb < 4096) begin
          bitbuf[nb] = 1'b0;
          nb++;
        end
        ones = 0;
      end
    end
  end

  // R11: line must not move across the rising edge
  int viol = 0;
  always @(posedge clk) begin
    automatic logic v = line_out;
    #1;
    if (line_out !== v) viol++;
  end

  task automatic send(input logic [7:0] d, input logic s, input logic e, output int hs);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = s;
    in_eof   = e;
    hs = -1;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk);
        #1;
        hs = cyc;
        break;
      end
    end
    if (hs < 0) check(1'b0, "R6", "handshake timeout", 0, 1);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_eof = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hs0, hs1, hs2, t0, base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(line_out == 1'b1, "R1", "line high in reset", line_out, 1);
    check(in_ready == 1'b0, "R1", "ready low in reset", in_ready, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R1/R5: idle flags only
    idle(60);
    check(flag_cnt >= 5, "R1", "idle flags seen", flag_cnt, 5);
    check(rx_n == 0, "R5", "no frame while idle", rx_n, 0);

    // Vector table: R2 R3 R4 R7 R8
    t0 = cyc;
    for (int i = 0; i < NV; i++) begin
      int hs;
      send(VEC[i][7:0], VEC[i][9], VEC[i][8], hs);
      if (i == 0) check((hs - t0) >= 1 && (hs - t0) <= 9, "R7", "idle accept latency",
                        hs - t0, 8);
    end
    idle(40);
    check(rx_n == NV, "R3", "bytes received", rx_n, NV);
    for (int i = 0; i < NV; i++) begin
      check(rx_byte[i] == int'(VEC[i][7:0]), "R4", "decoded byte", rx_byte[i], VEC[i][7:0]);
      check(rx_last[i] == VEC[i][8], "R8", "frame end position", rx_last[i], VEC[i][8]);
    end

    // R6: inserted zero at the byte boundary delays ready one period
    base = rx_n;
    send(8'h00, 1'b1, 1'b0, hs0);
    send(8'h1F, 1'b0, 1'b0, hs1);
    send(8'h00, 1'b0, 1'b1, hs2);
    idle(40);
    check(hs1 - hs0 == 8, "R6", "gap after plain byte", hs1 - hs0, 8);
    check(hs2 - hs1 == 9, "R6", "gap after stuffed byte", hs2 - hs1, 9);
    check(rx_n == base + 3 && rx_byte[base+1] == 8'h1F, "R4", "boundary-stuffed byte",
          rx_byte[base+1], 8'h1F);

    // R9: underrun closes frame
    base = rx_n;
    send(8'h11, 1'b1, 1'b0, hs0);
    idle(40);
    check(rx_n == base + 1, "R9", "underrun frame length", rx_n - base, 1);
    check(rx_last[base] == 1'b1 && rx_byte[base] == 8'h11, "R9", "underrun frame closed",
          rx_byte[base], 8'h11);

    // R10: start-of-frame inside a frame forces a closing flag
    base = rx_n;
    send(8'h22, 1'b1, 1'b0, hs0);
    send(8'h33, 1'b1, 1'b1, hs1);
    idle(40);
    check(hs1 - hs0 == 16, "R10", "sof accept gap", hs1 - hs0, 16);
    check(rx_n == base + 2 && rx_last[base] == 1'b1, "R10", "first frame closed",
          rx_last[base], 1);
    check(rx_byte[base+1] == 8'h33 && rx_last[base+1] == 1'b1, "R10", "second frame",
          rx_byte[base+1], 8'h33);

    // R11
    check(viol == 0, "R11", "line moved at rising edge", viol, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule